// File: doc/BRIEF.md
# PHY Register Read Sequencer

This block reads one 16-bit register of an Ethernet PHY through the indirect management interface of a banked controller register file. It reaches that register file as a simple bus master. It never touches the serial management wire itself. Instead it selects the right register bank through bit-set and bit-clear operations on the shared control register. It then loads the PHY register number into the management address register and raises the read command. It polls the management status register until the busy flag drops, withdraws the command, and fetches the result as two bytes.

A host pulses `start` with a 5-bit PHY register number. `busy` stays high while the sequence runs. A one-cycle `done` pulse returns either the 16-bit value or, if the busy flag never cleared within `MAX_POLLS` status reads, an error flag.

Top module: `phy_mgmt_rd`

## Requirements
- R1: Out of reset, `busy`, `done` and `err` are low, `phy_data` is zero, and neither `bus_we` nor `bus_re` is asserted.
- R2: A `start` pulse in idle latches `phy_reg` and raises `busy` in the next cycle. The first two bus operations select bank 2 on the shared control register at offset 0x1F: a bit-clear with mask 0x01, then a bit-set with mask 0x02.
- R3: Next, the PHY register number is written (zero-extended to 8 bits) to offset 0x14. After that, 0x01 is written to the command register at offset 0x12.
- R4: The block then selects bank 3 with a bit-set of mask 0x01 at 0x1F. It reads the status register at offset 0x0A repeatedly, and stops once bit 0 of the returned byte is 0.
- R5: After polling ends, for any reason, the block returns to bank 2 with a bit-clear of mask 0x01 at 0x1F and writes 0x00 to offset 0x12.
- R6: On success, the block reads offset 0x19 and then offset 0x18. It then pulses `done` for exactly one cycle with `err` low and `phy_data` = {byte from 0x19, byte from 0x18}. `busy` falls in the same cycle.
- R7: If MAX_POLLS status reads in a row all return bit 0 set, polling stops and the R5 steps still run. No result read follows. `done` pulses with `err` high and `phy_data` zero. Exactly MAX_POLLS-1 busy reads followed by a clear one still succeed.
- R8: A `start` pulse while `busy` is high is ignored. It adds no bus operation, does not change the register number in use, and produces no extra `done`.
- R9: Bus encoding works as follows. With `bus_we` high, `bus_op` 0 is a plain write, 1 sets the bits of `bus_wdata`, and 2 clears them. `bus_re` is a one-cycle read, and the slave returns `bus_rdata` in the following cycle. `bus_we` and `bus_re` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one PHY register read |
| phy_reg | input | PHY_AW | PHY register number, sampled with start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached; valid with done |
| phy_data | output | 16 | Read result; valid with done |
| bus_addr | output | 5 | Register bus offset |
| bus_wdata | output | 8 | Write data or bit mask |
| bus_we | output | 1 | Write strobe |
| bus_op | output | 2 | Write kind: 0 write, 1 bit-set, 2 bit-clear |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_re |

## Verification
The bench drives a behavioural banked slave that answers status reads with a chosen number of busy responses. Busy counts of zero, a few, exactly one below the limit, at the limit and well past it are tried. These runs separate the immediate-ready path, the normal polling loop, the off-by-one edge of the poll limit and the abort path. Result values with distinct high and low bytes expose a byte-order swap. The slave returns a busy status for any status read made outside bank 3, so a missing bank switch shows up as a timeout. A second `start` fired mid-sequence with a different register number checks that the running read is undisturbed, because every bus cycle is compared against the expected operation list.

// File: rtl/phy_mgmt_rd_pkg.sv
package phy_mgmt_rd_pkg;

  localparam int REG_AW = 5;
  localparam int REG_DW = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2
  } bus_op_e;

  typedef struct packed {
    logic              we;
    logic              re;
    bus_op_e           op;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] wdata;
  } bus_cmd_t;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h1F;
  localparam logic [REG_AW-1:0] OFS_MADDR = 5'h14;
  localparam logic [REG_AW-1:0] OFS_MCMD  = 5'h12;
  localparam logic [REG_AW-1:0] OFS_MSTAT = 5'h0A;
  localparam logic [REG_AW-1:0] OFS_RD_HI = 5'h19;
  localparam logic [REG_AW-1:0] OFS_RD_LO = 5'h18;

  localparam logic [REG_DW-1:0] MASK_BANK_LSB = 8'h01;
  localparam logic [REG_DW-1:0] MASK_BANK_MSB = 8'h02;
  localparam logic [REG_DW-1:0] CMD_READ      = 8'h01;
  localparam logic [REG_DW-1:0] CMD_NONE      = 8'h00;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_BANK_CLR,
    ST_BANK_SET,
    ST_ADDR_WR,
    ST_CMD_WR,
    ST_B3_SET,
    ST_POLL_RD,
    ST_POLL_WT,
    ST_POLL_CK,
    ST_B2_CLR,
    ST_CMD_CLR,
    ST_HI_RD,
    ST_HI_WT,
    ST_HI_CK,
    ST_LO_RD,
    ST_LO_WT,
    ST_LO_CK,
    ST_ABORT
  } seq_state_e;

endpackage

// File: rtl/phy_mgmt_poll_cnt.sv
module phy_mgmt_poll_cnt #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_rd_pkg::*;
#(
  parameter int PHY_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PHY_AW-1:0] phy_reg,
  input  logic              stat_busy,
  input  logic              poll_last,
  output bus_cmd_t          cmd,
  output logic              poll_clr,
  output logic              poll_inc,
  output logic              cap_hi,
  output logic              fin,
  output logic              fin_err,
  output logic              busy_nxt
);
  seq_state_e        st_q, st_d;
  logic [PHY_AW-1:0] reg_q;
  logic              tmo_q;
  logic              tmo_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      reg_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        reg_q <= phy_reg;
        tmo_q <= 1'b0;
      end else if (tmo_set) begin
        tmo_q <= 1'b1;
      end
    end
  end

  always_comb begin
    st_d     = st_q;
    cmd      = '0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    cap_hi   = 1'b0;
    fin      = 1'b0;
    fin_err  = 1'b0;
    tmo_set  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_BANK_CLR;
          poll_clr = 1'b1;
        end
      end
      ST_BANK_CLR: begin
        cmd.we = 1'b1; cmd.op = OP_CLEAR; cmd.addr = OFS_CTRL; cmd.wdata = MASK_BANK_LSB;
        st_d = ST_BANK_SET;
      end
      ST_BANK_SET: begin
        cmd.we = 1'b1; cmd.op = OP_SET; cmd.addr = OFS_CTRL; cmd.wdata = MASK_BANK_MSB;
        st_d = ST_ADDR_WR;
      end
      ST_ADDR_WR: begin
        cmd.we = 1'b1; cmd.op = OP_WRITE; cmd.addr = OFS_MADDR; cmd.wdata = REG_DW'(reg_q);
        st_d = ST_CMD_WR;
      end
      ST_CMD_WR: begin
        cmd.we = 1'b1; cmd.op = OP_WRITE; cmd.addr = OFS_MCMD; cmd.wdata = CMD_READ;
        st_d = ST_B3_SET;
      end
      ST_B3_SET: begin
        cmd.we = 1'b1; cmd.op = OP_SET; cmd.addr = OFS_CTRL; cmd.wdata = MASK_BANK_LSB;
        st_d = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        cmd.re = 1'b1; cmd.addr = OFS_MSTAT;
        st_d = ST_POLL_WT;
      end
      ST_POLL_WT: st_d = ST_POLL_CK;
      ST_POLL_CK: begin
        if (!stat_busy) begin
          st_d = ST_B2_CLR;
        end else if (poll_last) begin
          tmo_set = 1'b1;
          st_d    = ST_B2_CLR;
        end else begin
          poll_inc = 1'b1;
          st_d     = ST_POLL_RD;
        end
      end
      ST_B2_CLR: begin
        cmd.we = 1'b1; cmd.op = OP_CLEAR; cmd.addr = OFS_CTRL; cmd.wdata = MASK_BANK_LSB;
        st_d = ST_CMD_CLR;
      end
      ST_CMD_CLR: begin
        cmd.we = 1'b1; cmd.op = OP_WRITE; cmd.addr = OFS_MCMD; cmd.wdata = CMD_NONE;
        st_d = tmo_q ? ST_ABORT : ST_HI_RD;
      end
      ST_HI_RD: begin
        cmd.re = 1'b1; cmd.addr = OFS_RD_HI;
        st_d = ST_HI_WT;
      end
      ST_HI_WT: st_d = ST_HI_CK;
      ST_HI_CK: begin
        cap_hi = 1'b1;
        st_d   = ST_LO_RD;
      end
      ST_LO_RD: begin
        cmd.re = 1'b1; cmd.addr = OFS_RD_LO;
        st_d = ST_LO_WT;
      end
      ST_LO_WT: st_d = ST_LO_CK;
      ST_LO_CK: begin
        fin  = 1'b1;
        st_d = ST_IDLE;
      end
      ST_ABORT: begin
        fin     = 1'b1;
        fin_err = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign busy_nxt = (st_d != ST_IDLE);
endmodule

// File: rtl/phy_mgmt_bus_drv.sv
module phy_mgmt_bus_drv
  import phy_mgmt_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_cmd_t          cmd,
  input  logic              busy_nxt,
  output logic [REG_AW-1:0] bus_addr,
  output logic [REG_DW-1:0] bus_wdata,
  output logic              bus_we,
  output logic [1:0]        bus_op,
  output logic              bus_re,
  output logic              busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_op    <= 2'd0;
      bus_re    <= 1'b0;
      busy      <= 1'b0;
    end else begin
      bus_addr  <= cmd.addr;
      bus_wdata <= cmd.wdata;
      bus_we    <= cmd.we;
      bus_op    <= cmd.op;
      bus_re    <= cmd.re;
      busy      <= busy_nxt;
    end
  end
endmodule

// File: rtl/phy_mgmt_result.sv
module phy_mgmt_result #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_hi,
  input  logic              fin,
  input  logic              fin_err,
  input  logic [BYTE_W-1:0] rdata,
  output logic [2*BYTE_W-1:0] data,
  output logic              done,
  output logic              err
);
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      data <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= fin;
      if (cap_hi) hi_q <= rdata;
      if (fin) begin
        err  <= fin_err;
        data <= fin_err ? '0 : {hi_q, rdata};
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_rd.sv
module phy_mgmt_rd
  import phy_mgmt_rd_pkg::*;
#(
  parameter int PHY_AW    = 5,
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PHY_AW-1:0] phy_reg,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [15:0]       phy_data,
  output logic [4:0]        bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_we,
  output logic [1:0]        bus_op,
  output logic              bus_re,
  input  logic [7:0]        bus_rdata
);
  bus_cmd_t cmd;
  logic poll_clr, poll_inc, poll_last;
  logic cap_hi, fin, fin_err, busy_nxt;

  phy_mgmt_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  phy_mgmt_ctrl #(.PHY_AW(PHY_AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .phy_reg(phy_reg),
    .stat_busy(bus_rdata[0]), .poll_last(poll_last), .cmd(cmd),
    .poll_clr(poll_clr), .poll_inc(poll_inc), .cap_hi(cap_hi),
    .fin(fin), .fin_err(fin_err), .busy_nxt(busy_nxt)
  );

  phy_mgmt_bus_drv u_drv (
    .clk(clk), .rst(rst), .cmd(cmd), .busy_nxt(busy_nxt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_op(bus_op), .bus_re(bus_re), .busy(busy)
  );

  phy_mgmt_result #(.BYTE_W(REG_DW)) u_res (
    .clk(clk), .rst(rst), .cap_hi(cap_hi), .fin(fin), .fin_err(fin_err),
    .rdata(bus_rdata), .data(phy_data), .done(done), .err(err)
  );
endmodule

// File: rtl/phy_mgmt_rd_chk.sv
module phy_mgmt_rd_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] phy_data,
  input logic        bus_we,
  input logic        bus_re
);
  // R9
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  // R9
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we || bus_re) |-> busy);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (phy_data == 16'h0000));
endmodule

bind phy_mgmt_rd phy_mgmt_rd_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err(err), .phy_data(phy_data), .bus_we(bus_we), .bus_re(bus_re)
);

// File: tb/sim_phy_mgmt_rd.sv
module sim_phy_mgmt_rd;
  localparam int MAXP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  phy_reg = '0;
  logic        busy, done, err;
  logic [15:0] phy_data;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we, bus_re;
  logic [1:0]  bus_op;
  logic [7:0]  bus_rdata;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  phy_mgmt_rd #(.PHY_AW(5), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst(rst), .start(start), .phy_reg(phy_reg), .busy(busy),
    .done(done), .err(err), .phy_data(phy_data), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_op(bus_op), .bus_re(bus_re),
    .bus_rdata(bus_rdata)
  );

  // behavioural banked slave
  logic [7:0] ctrl;
  logic [7:0] regs [0:3][0:31];
  int         bsy_left;
  int         busy_len = 0;
  logic [7:0] res_hi = 8'h00, res_lo = 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      ctrl      <= 8'h00;
      bus_rdata <= 8'h00;
      bsy_left  <= 0;
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 32; a++) regs[b][a] <= 8'h00;
    end else begin
      if (bus_we) begin
        if (bus_addr == 5'h1F) begin
          case (bus_op)
            2'd0: ctrl <= bus_wdata;
            2'd1: ctrl <= ctrl | bus_wdata;
            default: ctrl <= ctrl & ~bus_wdata;
          endcase
        end else begin
          case (bus_op)
            2'd0: regs[ctrl[1:0]][bus_addr] <= bus_wdata;
            2'd1: regs[ctrl[1:0]][bus_addr] <= regs[ctrl[1:0]][bus_addr] | bus_wdata;
            default: regs[ctrl[1:0]][bus_addr] <= regs[ctrl[1:0]][bus_addr] & ~bus_wdata;
          endcase
          if (ctrl[1:0] == 2'd2 && bus_addr == 5'h12 && bus_op == 2'd0 && bus_wdata == 8'h01)
            bsy_left <= busy_len;
        end
      end
      if (bus_re) begin
        if (bus_addr == 5'h0A) begin
          if (ctrl[1:0] == 2'd3) begin
            bus_rdata <= {7'd0, bsy_left > 0};
            if (bsy_left > 0) bsy_left <= bsy_left - 1;
          end else begin
            bus_rdata <= 8'hFF;
          end
        end else if (ctrl[1:0] == 2'd2 && bus_addr == 5'h19) bus_rdata <= res_hi;
        else if (ctrl[1:0] == 2'd2 && bus_addr == 5'h18) bus_rdata <= res_lo;
        else bus_rdata <= regs[ctrl[1:0]][bus_addr];
      end
    end
  end

  // expected bus operation list: {re, we, op, addr, wdata}
  logic [16:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [16:0] wr_op(input logic [1:0] op, input logic [4:0] a, input logic [7:0] d);
    return {1'b0, 1'b1, op, a, d};
  endfunction
  function automatic logic [16:0] rd_op(input logic [4:0] a);
    return {1'b1, 1'b0, 2'd0, a, 8'd0};
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
    if (!rst && (bus_we || bus_re)) begin
      logic [16:0] act;
      act = bus_re ? {1'b1, bus_we, 2'd0, bus_addr, 8'd0} : {1'b0, 1'b1, bus_op, bus_addr, bus_wdata};
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9/R8: unexpected bus op actual %h expected none", act);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          fails++;
          $display("FAIL %s: bus op actual %h expected %h", t, act, e);
        end
      end
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic push(input logic [16:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic run_read(input logic [4:0] r, input int k, input logic [15:0] val, input bit poke);
    bit timeout;
    int waited;
    timeout  = (k >= MAXP);
    busy_len = k;
    res_hi   = val[15:8];
    res_lo   = val[7:0];
    push(wr_op(2'd2, 5'h1F, 8'h01), "R2");
    push(wr_op(2'd1, 5'h1F, 8'h02), "R2");
    push(wr_op(2'd0, 5'h14, {3'd0, r}), "R3");
    push(wr_op(2'd0, 5'h12, 8'h01), "R3");
    push(wr_op(2'd1, 5'h1F, 8'h01), "R4");
    for (int i = 0; i < ((k + 1 < MAXP) ? k + 1 : MAXP); i++) push(rd_op(5'h0A), timeout ? "R7" : "R4");
    push(wr_op(2'd2, 5'h1F, 8'h01), "R5");
    push(wr_op(2'd0, 5'h12, 8'h00), "R5");
    if (!timeout) begin
      push(rd_op(5'h19), "R6");
      push(rd_op(5'h18), "R6");
    end
    @(negedge clk);
    start   = 1'b1;
    phy_reg = r;
    @(negedge clk);
    start   = 1'b0;
    phy_reg = 5'h00;
    check("R2 busy raised", {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (4) @(negedge clk);
      start   = 1'b1;
      phy_reg = ~r;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    check(timeout ? "R7 done seen" : "R6 done seen", {31'd0, done}, 32'd1);
    check(timeout ? "R7 err" : "R6 err", {31'd0, err}, {31'd0, timeout});
    check(timeout ? "R7 data" : "R6 data", {16'd0, phy_data}, timeout ? 32'd0 : {16'd0, val});
    check("R6 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R6 done single cycle", {31'd0, done}, 32'd0);
    check(poke ? "R8 address kept" : "R3 address reg", {24'd0, regs[2][5'h14]}, {27'd0, r});
    check("R5 command cleared", {24'd0, regs[2][5'h12]}, 32'd0);
    check("R5 bank 2 at end", {30'd0, ctrl[1:0]}, 32'd2);
    check("R9 all ops issued", exp_q.size(), 32'd0);
    repeat (6) @(negedge clk);
    check(poke ? "R8 no extra done" : "R9 idle after", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done/err", {30'd0, done, err}, 32'd0);
    check("R1 data", {16'd0, phy_data}, 32'd0);
    check("R1 bus quiet", {30'd0, bus_we, bus_re}, 32'd0);

    run_read(5'd2, 0, 16'h0083, 1'b0);
    run_read(5'd3, 3, 16'h1400, 1'b0);
    run_read(5'h1F, MAXP - 1, 16'hC35A, 1'b0);
    run_read(5'd1, MAXP, 16'hBEEF, 1'b0);
    run_read(5'd4, 20, 16'h1111, 1'b0);
    run_read(5'd5, 1, 16'hA55A, 1'b0);
    run_read(5'd6, 2, 16'h1234, 1'b1);

    repeat (20) @(negedge clk);
    check("R9 idle quiet", {30'd0, bus_we, bus_re}, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule